// File: doc/BRIEF.md
# Staircase ADC Conversion Controller

This block sequences a counter-based analog-to-digital conversion. On a start request it clears a binary counter to zero and presents the count on a code output that feeds an external DAC. Each clock the count climbs by one step, so the DAC level forms a staircase. An external comparator reports whether that level is still under the held analog sample. The first code at which the comparator no longer reports "below" is stored as the result. The block then pulses a completion strobe and clears the counter, ready for the next sample.

The comparator line is asynchronous to the block, so it is passed through a flop synchronizer. A matching delay line carries each code and a validity flag alongside the synchronized comparator bit. Because of this, the stored code is the code that actually caused the trip, and not one that was driven later. The validity flag is flushed when a conversion ends. As a result, comparator readings left over from a previous conversion, or taken while idle, can never end a new one. A start request that arrives during a conversion is dropped and reported.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: A one-cycle `start_i` accepted while idle raises `busy_o` on the next cycle with `dac_code_o` = 0. While busy, `dac_code_o` rises by exactly one per clock until it reaches all-ones.
- R2: `cmp_below_i` = 1 means the DAC level is under the input. The stored `result_o` is the smallest code k whose comparator reading is 0. `done_o` is high in the cycle that begins k + SYNC_STAGES + 1 rising edges after the edge that accepted the start.
- R3: On completion the counter is cleared. `dac_code_o` is 0 in every cycle in which `busy_o` is low.
- R4: If the comparator never reads 0, the count holds at all-ones (2^CODE_W − 1) without wrapping. That code is stored, and `done_o` appears 2^CODE_W − 1 + SYNC_STAGES + 1 edges after the start edge.
- R5: A `start_i` seen on an edge at which a conversion is running is ignored and gives a one-cycle `start_lost_o` pulse. The running conversion's result and timing are unchanged. This includes a start on the completing edge, after which `busy_o` stays low.
- R6: `done_o` lasts exactly one cycle, and `busy_o` is low whenever `done_o` is high.
- R7: `result_o` changes only together with `done_o` and otherwise holds, including throughout the next conversion. After reset all outputs are 0.
- R8: A conversion started on the cycle right after a completion ignores comparator readings left over from the previous conversion and returns its own correct code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request |
| cmp_below_i | input | 1 | Asynchronous comparator: 1 while the DAC level is under the input |
| dac_code_o | output | CODE_W | Code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | CODE_W | Last converted code |
| start_lost_o | output | 1 | One-cycle flag: a start was dropped because the block was busy |

## Verification
Two functions can fall on the same edge: completing a conversion and rejecting a new start request. The bench provokes this by holding `start_i` high exactly in the cycle before the completing edge, using the input level to predict that edge. It then requires `done_o` and `start_lost_o` together, and `busy_o` low on that cycle and on the following one. A second collision, a start on the cycle right after completion, checks that the flushed delay line cannot let a stale comparator reading end the new conversion.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ramp_state_e;
endpackage

// File: rtl/ramp_sync.sv
// Flop chain that brings the asynchronous comparator into the clock domain.
module ramp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b1;
          else     chain_q[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b1;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ramp_align.sv
// Delays each issued code and its validity so they line up with the
// synchronized comparator bit. Flush empties the line on completion.
module ramp_align #(
  parameter int CODE_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic              vld_i,
  input  logic              flush_i,
  output logic [CODE_W-1:0] code_o,
  output logic              vld_o
);
  logic [CODE_W-1:0] code_q [STAGES];
  logic [STAGES-1:0] vld_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [CODE_W-1:0] code_in;
      logic              vld_in;
      if (s == 0) begin : g_first
        assign code_in = code_i;
        assign vld_in  = vld_i;
      end else begin : g_rest
        assign code_in = code_q[s-1];
        assign vld_in  = vld_q[s-1];
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          code_q[s] <= '0;
          vld_q[s]  <= 1'b0;
        end else begin
          code_q[s] <= code_in;
          vld_q[s]  <= vld_in & ~flush_i;
        end
      end
    end
  endgenerate

  assign code_o = code_q[STAGES-1];
  assign vld_o  = vld_q[STAGES-1];
endmodule

// File: rtl/ramp_counter.sv
// Saturating up-counter with synchronous clear.
module ramp_counter #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [CODE_W-1:0] cnt_o,
  output logic              at_max_o
);
  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)             cnt_q <= '0;
    else if (adv_i && !at_max_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = &cnt_q;

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($past(at_max_o) && !$past(clr_i)) |-> at_max_o); // R4
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cmp_below_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o,
  output logic              start_lost_o
);
  import ramp_adc_pkg::*;

  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  ramp_state_e       state_q;
  logic              cmp_s;
  logic [CODE_W-1:0] cnt;
  logic              at_max;
  logic [CODE_W-1:0] code_d;
  logic              vld_d;
  logic              finish;
  logic              accept;
  logic              running;
  logic [CODE_W-1:0] result_q;
  logic              done_q;
  logic              lost_q;

  assign running = (state_q == ST_RUN);
  assign accept  = !running && start_i;
  // Conversion ends on the first valid "not below" reading, or when the
  // top code has been seen without a trip.
  assign finish  = running && vld_d && (!cmp_s || (code_d == CODE_MAX));

  ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmp_below_i),
    .q_o (cmp_s)
  );

  ramp_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (accept || finish),
    .adv_i    (running && !finish),
    .cnt_o    (cnt),
    .at_max_o (at_max)
  );

  ramp_align #(.CODE_W(CODE_W), .STAGES(SYNC_STAGES)) u_align (
    .clk     (clk),
    .rst     (rst),
    .code_i  (cnt),
    .vld_i   (running),
    .flush_i (finish),
    .code_o  (code_d),
    .vld_o   (vld_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      result_q <= '0;
      done_q   <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      done_q <= finish;
      lost_q <= running && start_i;
      if (finish) begin
        state_q  <= ST_IDLE;
        result_q <= code_d;
      end else if (accept) begin
        state_q  <= ST_RUN;
      end
    end
  end

  assign dac_code_o   = cnt;
  assign busy_o       = running;
  assign done_o       = done_q;
  assign result_o     = result_q;
  assign start_lost_o = lost_q;

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |->
      (dac_code_o == (($past(dac_code_o) == CODE_MAX) ? CODE_MAX
                                                      : $past(dac_code_o) + 1'b1))); // R1
  AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (dac_code_o == '0)); // R1
  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (dac_code_o == '0)); // R3
  AST_LOST_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_lost_o |-> $past(busy_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o)); // R7
endmodule

// File: tb/ramp_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module ramp_adc_ctrl_tb_top;
  localparam int CODE_W = 8;
  localparam int SYNC   = 2;
  localparam int CMAX   = (1 << CODE_W) - 1;
  localparam int NV     = 8;
  localparam int LVL [NV] = '{0, 1, 7, 100, 254, 255, 256, 300};
  localparam int EXP [NV] = '{0, 1, 7, 100, 254, 255, 255, 255};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp_below;
  logic [CODE_W-1:0] dac_code, result;
  logic busy, done, lost;
  int level = 0;
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp_below = (int'(dac_code) < level);

  ramp_adc_ctrl #(.CODE_W(CODE_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk (clk), .rst (rst), .start_i (start), .cmp_below_i (cmp_below),
    .dac_code_o (dac_code), .busy_o (busy), .done_o (done),
    .result_o (result), .start_lost_o (lost)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts a conversion at the current negedge; optionally raises start again
  // for one cycle at negedge number inj. Returns with done seen (or timeout).
  task automatic run_conv(input int lvl, input int inj, output int res,
                          output int lat, output int lost_seen, output bit ramp_ok);
    int n;
    level = lvl;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    lost_seen = 0;
    ramp_ok = 1'b1;
    if (!(busy === 1'b1 && dac_code == '0)) ramp_ok = 1'b0;
    while (done !== 1'b1 && n < CMAX + 20) begin
      if (n == inj) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (n == inj) start = (done === 1'b1) ? 1'b0 : 1'b0;
      n++;
      if (lost === 1'b1) lost_seen++;
      if (busy === 1'b1 && int'(dac_code) != ((n < CMAX) ? n : CMAX)) ramp_ok = 1'b0;
    end
    res = int'(result);
    lat = n;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int res, lat, ls, prev;
    bit rok;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset values
    check(busy === 1'b0 && done === 1'b0 && lost === 1'b0, "R7 reset flags", int'(busy), 0);
    check(result == '0 && dac_code == '0, "R7 reset codes", int'(result), 0);

    // Table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      run_conv(LVL[i], -1, res, lat, ls, rok);
      check(rok, "R1 ramp from zero", 0, 1);
      check(res == EXP[i], (LVL[i] > CMAX) ? "R4 full-scale code" : "R2 result", res, EXP[i]);
      check(lat == EXP[i] + SYNC + 1, (LVL[i] > CMAX) ? "R4 full-scale latency" : "R2 latency", lat, EXP[i] + SYNC + 1);
      check(busy === 1'b0, "R6 busy low with done", int'(busy), 0);
      check(dac_code == '0, "R3 counter cleared", int'(dac_code), 0);
      @(negedge clk);
      check(done === 1'b0, "R6 done one cycle", int'(done), 0);
      check(int'(result) == EXP[i], "R7 result held", int'(result), EXP[i]);
    end

    // R7: result holds during the next conversion
    prev = int'(result);
    level = 40;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(int'(result) == prev, "R7 result held mid-conversion", int'(result), prev);
    while (done !== 1'b1) @(negedge clk);
    check(int'(result) == 40, "R2 result 40", int'(result), 40);
    @(negedge clk);

    // R5: start mid-conversion dropped and flagged
    run_conv(50, 10, res, lat, ls, rok);
    check(ls == 1, "R5 lost flag once", ls, 1);
    check(res == 50, "R5 result unaffected", res, 50);
    check(lat == 50 + SYNC + 1, "R5 latency unaffected", lat, 50 + SYNC + 1);
    @(negedge clk);

    // R5: start on the completing edge
    run_conv(20, 20 + SYNC, res, lat, ls, rok);
    check(done === 1'b1 && lost === 1'b1, "R5 done and lost together", int'(lost), 1);
    check(busy === 1'b0, "R5 busy low at completion", int'(busy), 0);
    @(negedge clk);
    check(busy === 1'b0 && dac_code == '0, "R5 start on completion ignored", int'(busy), 0);
    check(res == 20, "R5 result at collision", res, 20);

    // R8: restart right after completion, stale readings must not trip
    run_conv(5, -1, res, lat, ls, rok);
    check(res == 5, "R8 first result", res, 5);
    run_conv(200, -1, res, lat, ls, rok);
    check(res == 200, "R8 back-to-back result", res, 200);
    check(lat == 200 + SYNC + 1, "R8 back-to-back latency", lat, 200 + SYNC + 1);
    @(negedge clk);

    // R7: reset during a conversion
    level = 90;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && dac_code == '0 && result == '0, "R7 reset mid-run", int'(dac_code), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule